// File: doc/BRIEF.md
# Device Activity Monitor with Minute Timer

This block lets a management handler judge whether the system has been idle. Five device classes are watched: serial port, parallel port, floppy controller, keyboard controller and audio function. Either of two access paths may present a valid strobe with a class code. The matching class bit in an activity register is then set, and it stays set until software writes a 1 to that bit.

A periodic timer, gated by an enable bit, counts ticks from an external timebase. When a full minute's worth of ticks has arrived, it sets a timer-expired status bit. That bit drives the interrupt request for as long as the timer is enabled. The handler reads the activity bits once per interrupt and clears them along with the expired bit. It keeps its own count of consecutive idle minutes, outside this block.

Software sees two registers through a simple single-cycle write port and a combinational read port. The control register is at address 0. The activity register is at address 1.

Top module: `devact_mon`

## Requirements
- R1: After reset, the enable bit, the timer-expired bit and all activity bits are 0, and `smi_req` is 0.
- R2: A cycle with `acc_a_vld` or `acc_b_vld` high sets the bit of the activity register (address 1) that matches the class code on that path. The codes and bits are: 0 serial to bit 0, 1 parallel to bit 1, 2 floppy to bit 2, 3 keyboard to bit 3, 4 audio to bit 4. Both paths may set bits in the same cycle.
- R3: A class code of 5, 6 or 7, or a path whose valid strobe is low, sets no activity bit.
- R4: An activity bit stays set until software clears it. A write to address 1 clears each bit whose data bit is 1 and leaves every bit whose data bit is 0 unchanged.
- R5: If a write-1 clear and a set reach the same status bit in the same cycle, the bit ends set. This holds for an activity bit and for the timer-expired bit.
- R6: The timer counts `tick` cycles only while the enable bit (control bit 0) is 1. A cleared enable bit resets the count, so re-enabling starts a full new period.
- R7: While enabled, the TICKS_PER_MIN-th counted tick sets the timer-expired bit (control bit 1) at that clock edge. This repeats every TICKS_PER_MIN ticks.
- R8: `smi_req` is high exactly when both the timer-expired bit and the enable bit are 1. A control write clears the expired bit only when data bit 1 is 1. Disabling the timer keeps the expired bit.
- R9: A write to address 0 loads the enable bit from data bit 0. Reads return {0…, expired, enable} at address 0 and {0…, activity[4:0]} at address 1, with unused bits reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register address (0 control, 1 activity) |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for reg_addr |
| acc_a_vld | input | 1 | Access strobe, path A |
| acc_a_cls | input | 3 | Device class code, path A |
| acc_b_vld | input | 1 | Access strobe, path B |
| acc_b_cls | input | 3 | Device class code, path B |
| tick | input | 1 | Timebase tick, one cycle per count |
| smi_req | output | 1 | Management interrupt request level |

## Verification
The hardest situations to reach are the collisions: a write-1 clear landing in the very cycle a set arrives. For the timer bit, that set only comes on the final tick of a period. The bench counts ticks from a known start, so the count is known exactly. It then raises the last tick and the clearing write together. For the activity bits, it pairs the clearing write with a path-A strobe in one cycle. Restart after disable is reached by abandoning a partial period and then proving that a full count is needed again.

// File: rtl/devact_pkg.sv
package devact_pkg;
  localparam int N_CLS  = 5;
  localparam int CLS_W  = 3;
  localparam int ADDR_W = 1;

  typedef enum logic [CLS_W-1:0] {
    CLS_SERIAL   = 3'd0,
    CLS_PARALLEL = 3'd1,
    CLS_FLOPPY   = 3'd2,
    CLS_KBD      = 3'd3,
    CLS_AUDIO    = 3'd4
  } dev_cls_e;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 1'b0;
  localparam logic [ADDR_W-1:0] ADDR_ACT  = 1'b1;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_STS_BIT = 1;
endpackage

// File: rtl/devact_rst_sync.sv
module devact_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/devact_cls_dec.sv
module devact_cls_dec
  import devact_pkg::*;
(
  input  logic             vld,
  input  logic [CLS_W-1:0] cls,
  output logic [N_CLS-1:0] hit
);
  for (genvar i = 0; i < N_CLS; i++) begin : g_cls
    assign hit[i] = vld && (cls == CLS_W'(i));
  end
endmodule

// File: rtl/devact_minute_tmr.sv
module devact_minute_tmr #(
  parameter int TICKS_PER_MIN = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  output logic expire
);
  localparam int CW = $clog2(TICKS_PER_MIN + 1);
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_MIN - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_ce;

  always_comb begin
    expire = en && tick && (cnt_q == LAST);
    cnt_ce = 1'b0;
    cnt_d  = cnt_q;
    if (!en) begin
      cnt_ce = (cnt_q != '0);
      cnt_d  = '0;
    end else if (tick) begin
      cnt_ce = 1'b1;
      cnt_d  = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/devact_w1c_bits.sv
module devact_w1c_bits #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic d, ce;
    always_comb begin
      ce = set[i] || clr[i];
      d  = set[i] ? 1'b1 : 1'b0;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q[i] <= 1'b0;
      else if (ce) q[i] <= d;
    end
  end
endmodule

// File: rtl/devact_mon.sv
module devact_mon
  import devact_pkg::*;
#(
  parameter int TICKS_PER_MIN = 60,
  parameter int DW            = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              acc_a_vld,
  input  logic [CLS_W-1:0]  acc_a_cls,
  input  logic              acc_b_vld,
  input  logic [CLS_W-1:0]  acc_b_cls,
  input  logic              tick,
  output logic              smi_req
);
  logic             rst_sync_n;
  logic [N_CLS-1:0] hit_a, hit_b, act_set, act_clr, act_sts;
  logic             wr_ctrl, wr_act;
  logic             tmr_en, tmr_en_d, tmr_expire, tmr_sts;
  logic             unused_wdata;

  devact_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  devact_cls_dec u_dec_a (.vld(acc_a_vld), .cls(acc_a_cls), .hit(hit_a));
  devact_cls_dec u_dec_b (.vld(acc_b_vld), .cls(acc_b_cls), .hit(hit_b));

  always_comb begin
    wr_ctrl  = reg_wr && (reg_addr == ADDR_CTRL);
    wr_act   = reg_wr && (reg_addr == ADDR_ACT);
    act_set  = hit_a | hit_b;
    act_clr  = wr_act ? reg_wdata[N_CLS-1:0] : '0;
    tmr_en_d = wr_ctrl ? reg_wdata[CTRL_EN_BIT] : tmr_en;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  tmr_en <= 1'b0;
    else if (wr_ctrl) tmr_en <= tmr_en_d;
  end

  devact_minute_tmr #(.TICKS_PER_MIN(TICKS_PER_MIN)) u_tmr (
    .clk(clk), .rst_n(rst_sync_n), .en(tmr_en), .tick(tick),
    .expire(tmr_expire)
  );

  devact_w1c_bits #(.W(N_CLS)) u_act (
    .clk(clk), .rst_n(rst_sync_n), .set(act_set), .clr(act_clr),
    .q(act_sts)
  );

  devact_w1c_bits #(.W(1)) u_tsts (
    .clk(clk), .rst_n(rst_sync_n), .set(tmr_expire),
    .clr(wr_ctrl && reg_wdata[CTRL_STS_BIT]), .q(tmr_sts)
  );

  always_comb begin
    smi_req = tmr_sts && tmr_en;
    if (reg_addr == ADDR_CTRL)
      reg_rdata = {{(DW-2){1'b0}}, tmr_sts, tmr_en};
    else
      reg_rdata = {{(DW-N_CLS){1'b0}}, act_sts};
  end

  assign unused_wdata = ^reg_wdata[DW-1:N_CLS];
endmodule

// File: rtl/devact_mon_chk.sv
module devact_mon_chk
  import devact_pkg::*;
#(
  parameter int DW = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DW-1:0]     reg_wdata,
  input logic              acc_a_vld,
  input logic              acc_b_vld,
  input logic              tick,
  input logic              smi_req,
  input logic              tmr_en,
  input logic              tmr_sts,
  input logic [N_CLS-1:0]  act_sts
);
  logic [N_CLS-1:0] clr_mask;
  assign clr_mask = (reg_wr && reg_addr == ADDR_ACT) ? reg_wdata[N_CLS-1:0] : '0;

  // R4
  act_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(act_sts) & ~$past(clr_mask)) & ~act_sts) == '0));

  // R3
  act_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_a_vld && !acc_b_vld) |=> ((act_sts & ~$past(act_sts)) == '0));

  // R6
  tmr_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_en |=> !$rose(tmr_sts));

  // R7
  tmr_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmr_sts) |-> $past(tick));

  // R8
  smi_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(smi_req) |-> ($past(tick) || $past(reg_wr)));
endmodule

bind devact_mon devact_mon_chk #(.DW(DW)) u_chk (.*);

// File: tb/sim_devact_mon.sv
module sim_devact_mon;
  localparam int CLK_PERIOD = 10;
  localparam int TPM        = 5;
  localparam int DW         = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_wr;
  logic [0:0]    reg_addr;
  logic [DW-1:0] reg_wdata;
  logic [DW-1:0] reg_rdata;
  logic          acc_a_vld, acc_b_vld, tick, smi_req;
  logic [2:0]    acc_a_cls, acc_b_cls;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  devact_mon #(.TICKS_PER_MIN(TPM), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .acc_a_vld(acc_a_vld), .acc_a_cls(acc_a_cls),
    .acc_b_vld(acc_b_vld), .acc_b_cls(acc_b_cls),
    .tick(tick), .smi_req(smi_req)
  );

  // {a_vld, a_cls[2:0], b_vld, b_cls[2:0], expected activity[4:0]}
  localparam logic [12:0] VEC [8] = '{
    {1'b1, 3'd0, 1'b0, 3'd0, 5'b00001},
    {1'b0, 3'd0, 1'b1, 3'd1, 5'b00010},
    {1'b1, 3'd2, 1'b1, 3'd3, 5'b01100},
    {1'b1, 3'd4, 1'b1, 3'd4, 5'b10000},
    {1'b1, 3'd5, 1'b0, 3'd0, 5'b00000},
    {1'b0, 3'd2, 1'b1, 3'd7, 5'b00000},
    {1'b0, 3'd0, 1'b0, 3'd3, 5'b00000},
    {1'b1, 3'd3, 1'b1, 3'd0, 5'b01001}
  };

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic a, input logic [DW-1:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    step();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input string tag, input logic a, input logic [DW-1:0] exp);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      step();
    end
    tick = 1'b0;
  endtask

  task automatic smi(input string tag, input logic exp);
    chk(tag, {{(DW-1){1'b0}}, smi_req}, {{(DW-1){1'b0}}, exp});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    acc_a_vld = 1'b0; acc_a_cls = '0; acc_b_vld = 1'b0; acc_b_cls = '0; tick = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();

    // R1 reset state
    rd("R1 ctrl", 1'b0, 8'h00);
    rd("R1 act", 1'b1, 8'h00);
    smi("R1 smi", 1'b0);

    // R2 / R3 vector walk
    foreach (VEC[k]) begin
      wr(1'b1, 8'h1F);
      acc_a_vld = VEC[k][12]; acc_a_cls = VEC[k][11:9];
      acc_b_vld = VEC[k][8];  acc_b_cls = VEC[k][7:5];
      step();
      acc_a_vld = 1'b0; acc_b_vld = 1'b0;
      rd($sformatf("R2/R3 vector %0d", k), 1'b1, {3'b000, VEC[k][4:0]});
    end
    wr(1'b1, 8'h1F);

    // R4 sticky and write-1-to-clear
    acc_a_vld = 1'b1; acc_a_cls = 3'd0; acc_b_vld = 1'b1; acc_b_cls = 3'd4;
    step();
    acc_a_vld = 1'b0; acc_b_vld = 1'b0;
    repeat (4) step();
    rd("R4 sticky", 1'b1, 8'h11);
    wr(1'b1, 8'h00);
    rd("R4 write zero", 1'b1, 8'h11);
    wr(1'b1, 8'h01);
    rd("R4 clear one", 1'b1, 8'h10);
    wr(1'b1, 8'h10);
    rd("R4 clear rest", 1'b1, 8'h00);

    // R5 activity set wins over clear
    acc_a_vld = 1'b1; acc_a_cls = 3'd0;
    wr(1'b1, 8'h01);
    acc_a_vld = 1'b0;
    rd("R5 act set wins", 1'b1, 8'h01);
    wr(1'b1, 8'h1F);

    // R6 no counting while disabled
    ticks(10);
    rd("R6 disabled", 1'b0, 8'h00);
    smi("R6 disabled smi", 1'b0);

    // R7 period and repetition
    wr(1'b0, 8'h01);
    ticks(TPM - 1);
    smi("R7 before period", 1'b0);
    ticks(1);
    smi("R7 at period", 1'b1);
    rd("R9 ctrl read", 1'b0, 8'h03);
    rd("R9 act read independent", 1'b1, 8'h00);
    wr(1'b0, 8'h03);
    smi("R8 clear", 1'b0);
    ticks(TPM);
    smi("R7 repeat", 1'b1);
    wr(1'b0, 8'h03);

    // R6 restart after disable
    ticks(3);
    wr(1'b0, 8'h00);
    wr(1'b0, 8'h01);
    ticks(TPM - 1);
    smi("R6 restart partial", 1'b0);
    ticks(1);
    smi("R6 restart full", 1'b1);

    // R8 gating by enable, status held
    wr(1'b0, 8'h00);
    smi("R8 gated off", 1'b0);
    rd("R8 status held", 1'b0, 8'h02);
    wr(1'b0, 8'h01);
    smi("R8 gated on", 1'b1);

    // R5 timer status set wins over clear
    wr(1'b0, 8'h03);
    ticks(TPM - 1);
    tick = 1'b1;
    wr(1'b0, 8'h03);
    tick = 1'b0;
    smi("R5 tmr set wins", 1'b1);
    wr(1'b0, 8'h03);
    rd("R8 cleared keeps enable", 1'b0, 8'h01);

    summary();
  end
endmodule